// File: doc/BRIEF.md
# Per-core interrupt status and mailbox register block

This block is the register file that one processor core owns in an inter-processor interrupt scheme. Other agents post interrupt requests to the core by writing bit masks to a set port, and the core acknowledges them by writing masks to a clear port. A 32-bit enable word qualifies which pending bits may assert the interrupt. Eight 32-bit mailbox words carry message payloads between the cores.

The interrupt line is held in a register and does not follow a plain masked OR. A set write raises it when the new pending word has at least one enabled bit. A clear write lowers it only when the pending word becomes all zero and the enable word is nonzero. In every other cycle the line keeps its value. An enable write never moves the line.

The bus is a simple 32-bit word interface. Read data is combinational from the address. A one-cycle error pulse flags writes to the read-only status word and any access to an undefined offset.

Top module: `ipi_core_regs`

## Requirements
- R1: While reset is asserted and after its release, the status word, the enable word, all eight mailbox words, the interrupt output and the error output read as zero.
- R2: Only address bits [7:0] are decoded. The offsets are 0x00 status, 0x04 enable, 0x08 set port, 0x0C clear port, and 0x20 + 4*i for mailbox word i (i = 0..7). Higher address bits select nothing.
- R3: The enable word is readable, and a write replaces all 32 bits of it.
- R4: A set-port write ORs the write data into status. If the updated status ANDed with enable is nonzero, the interrupt goes high; otherwise it keeps its value. A read of the set port returns zero.
- R5: A clear-port write clears the status bits that are 1 in the write data. If the updated status is zero and enable is nonzero, the interrupt goes low; otherwise it keeps its value. A read of the clear port returns zero.
- R6: An enable write leaves the interrupt output unchanged.
- R7: A write to the status offset leaves status unchanged and raises the error output for one cycle.
- R8: Each of the eight mailbox words stores its own written value and returns it on read.
- R9: An access to any other offset (0x10 to 0x1C, a mailbox offset with bits [1:0] nonzero, or 0x40 and above) reads zero, changes no state and raises the error output for one cycle.
- R10: The interrupt, status, enable and mailbox changes take effect at the rising clock edge that samples the write. The error pulse is high during the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bus_addr | input | 12 | Byte address; only bits [7:0] are decoded |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; used only for error reporting |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Level interrupt to the core |
| err_o | output | 1 | One-cycle pulse after an illegal access |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle, so that each cycle carries at most one access. They also assume that the inputs are settled at zero before reset is released, because several properties compare against the value of the previous cycle. The bench drives one access per task call. It raises a strobe after a falling edge and drops it after the next falling edge, so both strobes are never active together. Every input is held low during and directly after reset.

// File: rtl/ipi_regs_pkg.sv
package ipi_regs_pkg;
  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_ENABLE,
    SEL_SET,
    SEL_CLEAR,
    SEL_MBOX
  } reg_sel_e;
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_regs_pkg::*;
#(
  parameter int MBOX_BASE  = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W     = $clog2(MBOX_WORDS),
  localparam int MBOX_END  = MBOX_BASE + 4 * MBOX_WORDS
) (
  input  logic [7:0]       offset_i,
  output reg_sel_e         sel_o,
  output logic [IDX_W-1:0] mbox_idx_o
);
  logic [31:0] off_u;

  always_comb begin
    off_u      = {24'h0, offset_i};
    sel_o      = SEL_NONE;
    mbox_idx_o = IDX_W'((offset_i - 8'(MBOX_BASE)) >> 2);
    unique case (offset_i)
      OFF_STATUS: sel_o = SEL_STATUS;
      OFF_ENABLE: sel_o = SEL_ENABLE;
      OFF_SET:    sel_o = SEL_SET;
      OFF_CLEAR:  sel_o = SEL_CLEAR;
      default: begin
        if (offset_i[1:0] == 2'b00 && off_u >= 32'(MBOX_BASE) && off_u < 32'(MBOX_END))
          sel_o = SEL_MBOX;
      end
    endcase
  end
endmodule

// File: rtl/ipi_status_irq.sv
module ipi_status_irq #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_enable_i,
  input  logic              we_set_i,
  input  logic              we_clear_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] enable_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] status_q, status_n;
  logic [DATA_W-1:0] enable_q, enable_n;
  logic              irq_q, irq_n;
  logic              upd_en;

  always_comb begin
    status_n = status_q;
    enable_n = enable_q;
    irq_n    = irq_q;
    if (we_enable_i) enable_n = wdata_i;
    if (we_set_i) begin
      status_n = status_q | wdata_i;
      if (status_n != '0 && (status_n & enable_q) != '0) irq_n = 1'b1;
    end
    if (we_clear_i) begin
      status_n = status_q & ~wdata_i;
      if (status_n == '0 && enable_q != '0) irq_n = 1'b0;
    end
  end

  assign upd_en = we_enable_i | we_set_i | we_clear_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      irq_q    <= 1'b0;
    end else if (upd_en) begin
      status_q <= status_n;
      enable_q <= enable_n;
      irq_q    <= irq_n;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;

  // R4: every bit written to the set port is pending afterwards
  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we_set_i |=> ((status_q & $past(wdata_i)) == $past(wdata_i)));
  // R5: every bit written to the clear port is gone afterwards
  a_r5_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we_clear_i |=> ((status_q & $past(wdata_i)) == '0));
  // R4: the line rises only after a set write
  a_r4_rise_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(we_set_i));
  // R5: the line falls only after a clear write that left nothing pending
  a_r5_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> ($past(we_clear_i) && status_q == '0 && enable_q != '0));
  // R6: enable writes leave the line alone
  a_r6_enable_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    we_enable_i |=> $stable(irq_q));
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  localparam int IDX_W     = $clog2(MBOX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [MBOX_WORDS];

  for (genvar g = 0; g < MBOX_WORDS; g++) begin : g_word
    logic word_en;
    assign word_en = we_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q[g] <= '0;
      else if (word_en) word_q[g] <= wdata_i;
    end
  end

  assign rdata_o = word_q[idx_i];

  // R8: a written word returns the written value on the next cycle
  a_r8_word_stored: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (word_q[$past(idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
  import ipi_regs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int MBOX_WORDS = 8,
  parameter int MBOX_BASE  = 32,
  localparam int IDX_W     = $clog2(MBOX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              err_o
);
  logic              rst_sync_n;
  reg_sel_e          sel;
  logic [IDX_W-1:0]  mbox_idx;
  logic [DATA_W-1:0] status_w, enable_w, mbox_rdata;
  logic              err_q, err_n;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];

  ipi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ipi_addr_decode #(.MBOX_BASE(MBOX_BASE), .MBOX_WORDS(MBOX_WORDS)) u_dec (
    .offset_i   (bus_addr[7:0]),
    .sel_o      (sel),
    .mbox_idx_o (mbox_idx)
  );

  ipi_status_irq #(.DATA_W(DATA_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .we_enable_i (bus_wr && sel == SEL_ENABLE),
    .we_set_i    (bus_wr && sel == SEL_SET),
    .we_clear_i  (bus_wr && sel == SEL_CLEAR),
    .wdata_i     (bus_wdata),
    .status_o    (status_w),
    .enable_o    (enable_w),
    .irq_o       (irq_o)
  );

  ipi_mailbox #(.DATA_W(DATA_W), .MBOX_WORDS(MBOX_WORDS)) u_mbox (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (bus_wr && sel == SEL_MBOX),
    .idx_i   (mbox_idx),
    .wdata_i (bus_wdata),
    .rdata_o (mbox_rdata)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: bus_rdata = status_w;
      SEL_ENABLE: bus_rdata = enable_w;
      SEL_MBOX:   bus_rdata = mbox_rdata;
      default:    bus_rdata = '0;
    endcase
  end

  always_comb begin
    err_n = (bus_wr && (sel == SEL_NONE || sel == SEL_STATUS)) ||
            (bus_rd && sel == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_n;
  end

  assign err_o = err_q;

  // R7: a status write leaves status untouched
  a_r7_status_readonly: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr[7:0] == OFF_STATUS) |=> $stable(status_w));
  // R9: an error pulse follows only a bus access
  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_o |-> $past(bus_wr || bus_rd));
  // R4 / R5: the set and clear ports read as zero
  a_r5_ports_read_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr[7:0] == OFF_SET || bus_addr[7:0] == OFF_CLEAR) |-> bus_rdata == '0);
  // R9: undefined offsets change neither enable nor status
  a_r9_undef_no_state: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && sel == SEL_NONE) |=> ($stable(status_w) && $stable(enable_w)));
endmodule

// File: tb/sim_ipi_core_regs.sv
module sim_ipi_core_regs;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string       tag;
    int          kind;   // 0 read data, 1 irq, 2 err
    logic [31:0] expv;
  } exp_item_t;

  logic        clk, rst_n, bus_wr, bus_rd, irq_o, err_o;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  exp_item_t sb_q[$];
  event      chk_ev;
  int        n_chk, n_fail;
  bit        done;

  ipi_core_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Monitor: pops expected items and compares them with the outputs.
  always begin
    @(chk_ev);
    while (sb_q.size() > 0) begin
      exp_item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {31'h0, irq_o};
        default: act = {31'h0, err_o};
      endcase
      n_chk++;
      if (act !== it.expv) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.expv);
      end
    end
  end

  task automatic push_exp(input string tag, input int kind, input logic [31:0] v);
    exp_item_t it;
    it.tag = tag; it.kind = kind; it.expv = v;
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    push_exp(tag, 0, e);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic reset_checks();
    push_exp("R1 irq after reset", 1, 0);
    push_exp("R1 err after reset", 2, 0);
    rd(12'h000, 0, "R1 status after reset");
    rd(12'h004, 0, "R1 enable after reset");
    rd(12'h020, 0, "R1 mailbox0 after reset");
    rd(12'h03C, 0, "R1 mailbox7 after reset");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    do_reset();
    reset_checks();

    // R3 enable is read/write, whole-word replace
    wr(12'h004, 32'h0000_00F0);
    rd(12'h004, 32'h0000_00F0, "R3 enable readback");
    wr(12'h004, 32'h0000_0001);
    rd(12'h004, 32'h0000_0001, "R3 enable replaced");
    wr(12'h004, 32'h0000_00F0);

    // R4 set ORs, no enabled bit -> line stays low
    wr(12'h008, 32'h0000_0003);
    push_exp("R4 irq low, no enabled pending", 1, 0);
    rd(12'h000, 32'h0000_0003, "R4 status after set");
    rd(12'h008, 0, "R4 set port reads zero");
    // R10 enabled bit raises the line at the sampling edge
    wr(12'h008, 32'h0000_0010);
    push_exp("R10 irq high after enabled set", 1, 1);
    rd(12'h000, 32'h0000_0013, "R4 status OR accumulates");

    // R5 partial clear keeps the line
    wr(12'h00C, 32'h0000_0003);
    push_exp("R5 irq kept, status nonzero", 1, 1);
    rd(12'h000, 32'h0000_0010, "R5 status after clear");
    rd(12'h00C, 0, "R5 clear port reads zero");
    // R6 enable write does not move the line
    wr(12'h004, 32'h0);
    push_exp("R6 irq kept on enable write", 1, 1);
    // R5 clear to zero with enable zero keeps the line
    wr(12'h00C, 32'h0000_0010);
    push_exp("R5 irq kept, enable zero", 1, 1);
    rd(12'h000, 0, "R5 status cleared");
    wr(12'h004, 32'h0000_0001);
    push_exp("R6 irq kept on enable write 2", 1, 1);
    wr(12'h00C, 32'h0);
    push_exp("R5 irq lowered, status zero enable nonzero", 1, 0);

    // R4 pending bit not enabled, then enabled by enable write
    wr(12'h008, 32'h0000_0002);
    push_exp("R4 irq low, pending not enabled", 1, 0);
    wr(12'h004, 32'h0000_0002);
    push_exp("R6 irq low after enabling pending", 1, 0);
    wr(12'h008, 32'h0);
    push_exp("R4 irq raised by empty set", 1, 1);

    // R7 status write ignored and flagged
    wr(12'h000, 32'hFFFF_FFFF);
    push_exp("R7 err pulse", 2, 1);
    rd(12'h000, 32'h0000_0002, "R7 status unchanged");
    push_exp("R7 err one cycle", 2, 0);

    // R8 / R2 mailbox words, through an aliased upper address
    for (int i = 0; i < 8; i++) wr(12'hA20 + 12'(4*i), 32'hC0DE_0000 + 32'(i * 32'h111));
    for (int i = 0; i < 8; i++)
      rd(12'h020 + 12'(4*i), 32'hC0DE_0000 + 32'(i * 32'h111), "R8 mailbox word");
    wr(12'hF04, 32'h0000_0006);
    rd(12'h004, 32'h0000_0006, "R2 enable via aliased address");

    // R9 undefined offsets
    wr(12'h014, 32'hDEAD_BEEF);
    push_exp("R9 err after undefined write", 2, 1);
    rd(12'h014, 0, "R9 undefined read zero");
    push_exp("R9 err after undefined read", 2, 1);
    rd(12'h040, 0, "R9 offset 0x40 reads zero");
    wr(12'h022, 32'h1234_5678);
    push_exp("R9 err after misaligned write", 2, 1);
    rd(12'h020, 32'hC0DE_0000, "R9 mailbox0 untouched");
    push_exp("R9 err clear after legal read", 2, 0);
    rd(12'h000, 32'h0000_0002, "R9 status untouched");
    rd(12'h004, 32'h0000_0006, "R9 enable untouched");

    // R1 second reset
    do_reset();
    reset_checks();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule